// File: doc/BRIEF.md
# Power-of-Two Clock Enable Prescaler

The block turns a free-running oscillator clock into a set of low-rate enable pulses for the peripherals of a small controller. A divide-by-six stage first produces one tick per instruction cycle. A single shared binary chain counts those ticks, and each consumer picks one of twelve power-of-two taps of that chain, from 1/2 to 1/4096 of the instruction rate. No derived clocks are created: every output is a one-clock-wide enable in the oscillator domain, apart from the clock-out level.

Four consumers receive pulses: timer 1, timer 2, the internal shift clock of the serial interface, and the converter control clock. A fifth ratio drives a square-wave clock-out. The clock-out and the serial clock share one pin. A serial-enable input decides which of them owns the pin. While serial is enabled, the clock-out level is held low and the pin-select output reports serial ownership. Timer 2 and the serial engine choose between this internal clock and an external one on their own side.

Top module: `pow2_prescaler`

## Requirements
- R1: While rst_ni is low, every tick output, ckout_o and pin_is_sck_o are 0. Reset also clears the divide-by-six counter and the shared chain.
- R2: The instruction tick comes every 6 clocks, and the chain advances once per tick. For code 1 the first pulse is registered exactly 12 clock edges after reset is released.
- R3: A ratio code c in 1..12 makes the matching tick output high for one clock after every edge m (counted from reset release, m > 0) with m mod (6·2^c) = 0, and low at every other edge.
- R4: Codes 0, 13, 14 and 15 make the matching tick output stay 0. With such a code on the clock-out, ckout_o keeps its level.
- R5: All consumers share one chain. Consumers given equal codes pulse in the same clock cycles.
- R6: With serial disabled, ckout_o starts at 0 and inverts at each edge where its code's tap fires. This gives a 50 % square wave with a period of 12·2^c clocks.
- R7: pin_is_sck_o equals ser_enable_i as sampled at the previous edge. At any edge where ser_enable_i is 1, ckout_o is forced to 0, and this takes priority over a toggle at the same edge.
- R8: ser_tick_o is 0 after any edge where ser_enable_i was 0, whatever its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr1_code_i | input | 4 | Ratio code for timer 1 |
| tmr2_code_i | input | 4 | Ratio code for timer 2 |
| ser_code_i | input | 4 | Ratio code for the serial shift clock |
| adc_code_i | input | 4 | Ratio code for the converter control clock |
| ckout_code_i | input | 4 | Ratio code for the clock-out square wave |
| ser_enable_i | input | 1 | Serial interface enable; gives the shared pin to the serial clock |
| tmr1_tick_o | output | 1 | Timer 1 enable pulse |
| tmr2_tick_o | output | 1 | Timer 2 enable pulse |
| ser_tick_o | output | 1 | Serial shift enable pulse |
| adc_tick_o | output | 1 | Converter control enable pulse |
| ckout_o | output | 1 | Clock-out square-wave level |
| pin_is_sck_o | output | 1 | 1 when the shared pin carries the serial clock |

## Verification
Two functions can fall in the same cycle. The first is a serial-enable change at an edge where the clock-out tap fires: the hold to 0 must win over the toggle. The second is several consumers pulsing together off the one chain. The bench toggles ser_enable_i on periods that are not multiples of the tap periods, so enable changes land on toggle edges as well as between them. It also runs configurations with equal codes on several consumers. Every edge is judged against an arithmetic model of the edge count since reset, with the serial gating and hold priority applied to that model.

// File: rtl/pow2_prescaler_pkg.sv
package pow2_prescaler_pkg;
  localparam int unsigned DEF_OSC_DIV = 6;
  localparam int unsigned DEF_STAGES  = 12;
  localparam int unsigned DEF_CODE_W  = 4;

  typedef enum int unsigned {
    CONS_TMR1 = 0,
    CONS_TMR2 = 1,
    CONS_SER  = 2,
    CONS_ADC  = 3
  } consumer_e;

  localparam int unsigned NUM_PULSE = 4;
endpackage

// File: rtl/cycle_tick_gen.sv
module cycle_tick_gen #(
  parameter int unsigned DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pow2_chain.sv
module pow2_chain #(
  parameter int unsigned STAGES = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [STAGES-1:0] taps_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chain_q <= '0;
    else if (tick_i) chain_q <= chain_q + STAGES'(1);
  end

  // tap i fires on the tick that carries out of bit i: once per 2^(i+1) ticks
  for (genvar i = 0; i < STAGES; i++) begin : g_tap
    assign taps_o[i] = tick_i & (&chain_q[i:0]);
  end
endmodule

// File: rtl/tap_select.sv
module tap_select #(
  parameter int unsigned STAGES = 12,
  parameter int unsigned CODE_W = 4
) (
  input  logic [STAGES-1:0] taps_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  // code k selects tap k-1; codes outside 1..STAGES match nothing
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      if (code_i == CODE_W'(i + 1)) hit_o = taps_i[i];
    end
  end
endmodule

// File: rtl/clkout_toggle.sv
module clkout_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic hold_i,
  output logic level_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     level_q <= 1'b0;
    else if (hold_i) level_q <= 1'b0;
    else if (hit_i)  level_q <= ~level_q;
  end

  assign level_o = level_q;
endmodule

// File: rtl/pow2_prescaler.sv
module pow2_prescaler
  import pow2_prescaler_pkg::*;
#(
  parameter int unsigned OSC_DIV = DEF_OSC_DIV,
  parameter int unsigned STAGES  = DEF_STAGES,
  parameter int unsigned CODE_W  = DEF_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] tmr1_code_i,
  input  logic [CODE_W-1:0] tmr2_code_i,
  input  logic [CODE_W-1:0] ser_code_i,
  input  logic [CODE_W-1:0] adc_code_i,
  input  logic [CODE_W-1:0] ckout_code_i,
  input  logic              ser_enable_i,
  output logic              tmr1_tick_o,
  output logic              tmr2_tick_o,
  output logic              ser_tick_o,
  output logic              adc_tick_o,
  output logic              ckout_o,
  output logic              pin_is_sck_o
);
  logic              instr_tick;
  logic [STAGES-1:0] taps;
  logic [CODE_W-1:0] code_arr [NUM_PULSE];
  logic [NUM_PULSE-1:0] gate;
  logic [NUM_PULSE-1:0] hit;
  logic [NUM_PULSE-1:0] tick_q;
  logic              ck_hit;
  logic              sck_q;

  cycle_tick_gen #(.DIV(OSC_DIV)) u_cyc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (instr_tick)
  );

  pow2_chain #(.STAGES(STAGES)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (instr_tick),
    .taps_o (taps)
  );

  assign code_arr[CONS_TMR1] = tmr1_code_i;
  assign code_arr[CONS_TMR2] = tmr2_code_i;
  assign code_arr[CONS_SER]  = ser_code_i;
  assign code_arr[CONS_ADC]  = adc_code_i;

  always_comb begin
    gate           = '1;
    gate[CONS_SER] = ser_enable_i;
  end

  for (genvar c = 0; c < NUM_PULSE; c++) begin : g_cons
    tap_select #(.STAGES(STAGES), .CODE_W(CODE_W)) u_sel (
      .taps_i (taps),
      .code_i (code_arr[c]),
      .hit_o  (hit[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_q[c] <= 1'b0;
      else         tick_q[c] <= hit[c] & gate[c];
    end
  end

  tap_select #(.STAGES(STAGES), .CODE_W(CODE_W)) u_ck_sel (
    .taps_i (taps),
    .code_i (ckout_code_i),
    .hit_o  (ck_hit)
  );

  clkout_toggle u_ck (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (ck_hit),
    .hold_i  (ser_enable_i),
    .level_o (ckout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= ser_enable_i;
  end

  assign tmr1_tick_o  = tick_q[CONS_TMR1];
  assign tmr2_tick_o  = tick_q[CONS_TMR2];
  assign ser_tick_o   = tick_q[CONS_SER];
  assign adc_tick_o   = tick_q[CONS_ADC];
  assign pin_is_sck_o = sck_q;
endmodule

// File: rtl/pow2_prescaler_chk.sv
module pow2_prescaler_chk #(
  parameter int unsigned STAGES = 12,
  parameter int unsigned CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] tmr1_code_i,
  input logic [CODE_W-1:0] tmr2_code_i,
  input logic [CODE_W-1:0] ser_code_i,
  input logic [CODE_W-1:0] adc_code_i,
  input logic [CODE_W-1:0] ckout_code_i,
  input logic              ser_enable_i,
  input logic              tmr1_tick_o,
  input logic              tmr2_tick_o,
  input logic              ser_tick_o,
  input logic              adc_tick_o,
  input logic              ckout_o,
  input logic              pin_is_sck_o
);
  logic t1_bad, adc_bad;
  assign t1_bad  = (tmr1_code_i == '0) || (tmr1_code_i > CODE_W'(STAGES));
  assign adc_bad = (adc_code_i == '0)  || (adc_code_i > CODE_W'(STAGES));

  assert_tick_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr1_tick_o |=> !tmr1_tick_o);

  assert_bad_code_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t1_bad |=> !tmr1_tick_o);

  assert_adc_bad_code_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_bad |=> !adc_tick_o);

  assert_shared_chain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr1_code_i == tmr2_code_i) |=> (tmr1_tick_o == tmr2_tick_o));

  assert_pin_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_enable_i |=> (pin_is_sck_o && !ckout_o));

  assert_pin_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_enable_i |=> !pin_is_sck_o);

  assert_ser_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_enable_i |=> !ser_tick_o);

  // unused in properties but kept for a uniform port list
  logic unused_ok;
  assign unused_ok = ^{ser_code_i, ckout_code_i};
endmodule

bind pow2_prescaler pow2_prescaler_chk #(.STAGES(STAGES), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/pow2_prescaler_tb.sv
module pow2_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] t1_code = '0, t2_code = '0, sr_code = '0, ad_code = '0, ck_code = '0;
  logic       ser_en = 1'b0;
  logic       t1_tick, t2_tick, sr_tick, ad_tick, ck_lvl, pin_sck;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pow2_prescaler u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .tmr1_code_i  (t1_code),
    .tmr2_code_i  (t2_code),
    .ser_code_i   (sr_code),
    .adc_code_i   (ad_code),
    .ckout_code_i (ck_code),
    .ser_enable_i (ser_en),
    .tmr1_tick_o  (t1_tick),
    .tmr2_tick_o  (t2_tick),
    .ser_tick_o   (sr_tick),
    .adc_tick_o   (ad_tick),
    .ckout_o      (ck_lvl),
    .pin_is_sck_o (pin_sck)
  );

  task automatic check(input logic act, input logic exp, input string req, input int m);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0b expected %0b", req, m, act, exp);
    end
  endtask

  function automatic bit code_ok(input int code);
    return (code >= 1) && (code <= 12);
  endfunction

  function automatic bit exp_hit(input int code, input int m);
    if (!code_ok(code) || m == 0) return 1'b0;
    return (m % (6 << code)) == 0;
  endfunction

  function automatic string tick_req(input int code);
    return code_ok(code) ? "R3" : "R4";
  endfunction

  task automatic run_cfg(input int c1, input int c2, input int cs, input int ca,
                         input int cc, input bit ser0, input int ser_per, input int n);
    logic exp_ck;
    @(negedge clk);
    rst_ni = 1'b0;
    t1_code = 4'(c1); t2_code = 4'(c2); sr_code = 4'(cs);
    ad_code = 4'(ca); ck_code = 4'(cc); ser_en = ser0;
    @(negedge clk);
    // R1: outputs held low in reset, even with live codes and serial enabled
    check(t1_tick, 1'b0, "R1", 0);
    check(t2_tick, 1'b0, "R1", 0);
    check(sr_tick, 1'b0, "R1", 0);
    check(ad_tick, 1'b0, "R1", 0);
    check(ck_lvl,  1'b0, "R1", 0);
    check(pin_sck, 1'b0, "R1", 0);
    exp_ck = 1'b0;
    rst_ni = 1'b1;
    for (int m = 1; m <= n; m++) begin
      @(posedge clk);
      @(negedge clk);
      check(t1_tick, exp_hit(c1, m), tick_req(c1), m);
      check(t2_tick, exp_hit(c2, m), tick_req(c2), m);
      check(ad_tick, exp_hit(ca, m), tick_req(ca), m);
      check(sr_tick, ser_en & exp_hit(cs, m), ser_en ? tick_req(cs) : "R8", m);
      if (ser_en)              exp_ck = 1'b0;
      else if (exp_hit(cc, m)) exp_ck = ~exp_ck;
      check(ck_lvl, exp_ck, ser_en ? "R7" : (code_ok(cc) ? "R6" : "R4"), m);
      check(pin_sck, ser_en, "R7", m);
      if (c1 == 1 && (m == 6 || m == 12)) check(t1_tick, m == 12, "R2", m);
      if (c1 == c2) check(t1_tick, t2_tick, "R5", m);
      if (c1 == ca) check(ad_tick, t1_tick, "R5", m);
      if (ser_per > 0 && (m % ser_per) == 0) ser_en = ~ser_en;
    end
  endtask

  initial begin
    run_cfg(1, 2, 3, 4, 5, 1'b1, 1000, 2000);
    run_cfg(6, 7, 8, 9, 1, 1'b0, 37, 7000);
    run_cfg(10, 11, 12, 0, 13, 1'b1, 0, 50000);
    run_cfg(14, 15, 3, 3, 12, 1'b0, 0, 50000);
    run_cfg(2, 2, 2, 2, 2, 1'b0, 0, 300);
    run_cfg(2, 2, 3, 2, 3, 1'b0, 24, 600);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule